// File: doc/BRIEF.md
# Sized Load-Store Unit with Address-Window Traps

This block performs memory loads and stores of 1, 2, 4 or 8 bytes for a 64-bit datapath. A request carries an opcode, a base register value, a 64-bit immediate and, for stores, the data to write. The unit adds base and immediate to form the effective address. One shared path checks every access size against a null guard region and a lower and upper bound supplied as inputs. It then drives a byte-addressed, word-wide memory port that has per-lane byte enables.

Memory is little-endian. Byte k of a value lives at effective address + k, and it sits in lane (address mod 8) of the aligned memory word. An access that spills over an 8-byte word boundary takes two memory cycles, the lower word first. The unit then merges the read lanes into one zero-extended 64-bit result.

An access that touches any byte outside the allowed range does not reach memory. The unit returns a precise trap at once, which reports whether the access was a load or a store and gives the effective address.

Top module: `sized_lsu`

## Requirements
- R1: Opcodes 30, 31, 32 and 33 are loads of 1, 2, 4 and 8 bytes. Opcodes 34, 35, 36 and 37 are stores of 1, 2, 4 and 8 bytes. A request with any other opcode is ignored: it gives no response and no memory cycle, and `req_ready` stays high.
- R2: The effective address is `req_base + req_imm` modulo 2^64. `mem_addr` is a word address with bits 2:0 equal to zero. `mem_be[i]` is set exactly for lane i, which is byte `mem_addr + i`, when that byte belongs to the access.
- R3: A store writes byte k of `req_wdata` (bits 8k+7:8k) to address EA + k, and it leaves every other byte of memory unchanged.
- R4: A load returns in `resp_data` the bytes at EA, EA+1, … in little-endian order, zero-extended to 64 bits, and sets `resp_wb_en`.
- R5: An access that fits in one aligned 8-byte word uses exactly one memory cycle. An access that crosses a word boundary uses exactly two: first the word that holds EA, then the next word up.
- R6: An access is invalid when EA is below 4096, when EA is below `win_lo`, when its last byte EA+n−1 is above `win_hi`, or when that last byte would pass 2^64−1. An access whose last byte equals `win_hi` is valid.
- R7: An invalid access produces `resp_valid` and `trap_valid` in the cycle after the acceptance edge, with `resp_wb_en` low. `trap_store` is 1 for a store and 0 for a load, and `trap_addr` holds EA.
- R8: An invalid access drives no memory cycle, and a store that traps writes no byte.
- R9: A request is taken at a clock edge where `req_valid` and `req_ready` are high. `req_ready` is low while a memory access is in flight. A valid access gives its response (`resp_valid` high for one cycle) after the second edge following acceptance if it needs one memory cycle, or after the third edge if it needs two.
- R10: `mem_rdata` is taken as the data for the word that was addressed in the previous cycle.
- R11: During and right after reset, `req_ready` is 1 and `mem_en`, `resp_valid` and `trap_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_op | input | 8 | Opcode selecting load/store and size |
| req_base | input | 64 | Base register value |
| req_imm | input | 64 | Immediate offset |
| req_wdata | input | 64 | Store data, low bytes used for narrow stores |
| win_lo | input | 64 | Lowest valid byte address |
| win_hi | input | 64 | Highest valid byte address |
| req_ready | output | 1 | Unit idle and able to take a request |
| mem_en | output | 1 | Memory cycle active |
| mem_we | output | 1 | Memory cycle is a write |
| mem_addr | output | 64 | Word-aligned memory address |
| mem_be | output | 8 | Byte-lane enables |
| mem_wdata | output | 64 | Lane-aligned write data |
| mem_rdata | input | 64 | Read word, one cycle after the enable |
| resp_valid | output | 1 | Response pulse |
| resp_wb_en | output | 1 | Load result is to be written back |
| resp_data | output | 64 | Zero-extended load result |
| trap_valid | output | 1 | Access trap |
| trap_store | output | 1 | Trap kind: 1 store, 0 load |
| trap_addr | output | 64 | Faulting effective address |

## Verification
The bench builds the unit with its default parameters: 64-bit data and address, opcodes at 30 and 34, and a 4096-byte guard region. It also changes the window inputs while it runs. With a 512-byte window starting right at the end of the guard page, both the window edges and the crossings of word boundaries are in reach. A window that starts at zero lets the guard region alone decide, and an upper bound of all ones lets the test reach the point where the address wraps past the top of the address space.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

   typedef enum logic [1:0] {
      LSZ_BYTE  = 2'd0,
      LSZ_HALF  = 2'd1,
      LSZ_WORD  = 2'd2,
      LSZ_DWORD = 2'd3
   } lsu_size_e;

   typedef enum logic [1:0] {
      LS_IDLE,
      LS_LO,
      LS_HI,
      LS_DONE
   } lsu_state_e;

   // Number of bytes an access of the given size touches.
   function automatic int size_bytes(lsu_size_e s);
      return 1 << int'(s);
   endfunction

endpackage

// File: rtl/lsu_addr_check.sv
module lsu_addr_check
   import lsu_pkg::*;
#(
   parameter int              AW          = 64,
   parameter longint unsigned GUARD_BYTES = 4096
) (
   input  logic [AW-1:0] base,
   input  logic [AW-1:0] imm,
   input  lsu_size_e     size,
   input  logic [AW-1:0] win_lo,
   input  logic [AW-1:0] win_hi,
   output logic [AW-1:0] ea,
   output logic          bad
);
   localparam int GUARD_LOG  = $clog2(GUARD_BYTES);
   localparam bit GUARD_POW2 = ((GUARD_BYTES & (GUARD_BYTES - 1)) == 0);

   logic [AW:0] last_x;
   logic        in_guard;

   assign ea     = base + imm;
   // One extra bit catches an access whose tail wraps past the top.
   assign last_x = {1'b0, ea} + (AW+1)'(size_bytes(size) - 1);

   generate
      if (GUARD_POW2) begin : g_guard_mask
         assign in_guard = (ea[AW-1:GUARD_LOG] == '0);
      end else begin : g_guard_cmp
         assign in_guard = (ea < AW'(GUARD_BYTES));
      end
   endgenerate

   assign bad = in_guard
              | (ea < win_lo)
              | last_x[AW]
              | (last_x[AW-1:0] > win_hi);

endmodule

// File: rtl/lsu_lane_map.sv
module lsu_lane_map
   import lsu_pkg::*;
#(
   parameter int XLEN = 64,
   localparam int LANES = XLEN / 8,
   localparam int OFF_W = $clog2(LANES)
) (
   input  logic [OFF_W-1:0] off,
   input  lsu_size_e        size,
   input  logic [XLEN-1:0]  wdata,
   output logic [LANES-1:0] be_lo,
   output logic [LANES-1:0] be_hi,
   output logic             split,
   output logic [XLEN-1:0]  wd_lo,
   output logic [XLEN-1:0]  wd_hi
);
   logic [2*LANES-1:0] span;
   logic [XLEN-1:0]    wkeep;

   // Lane i of the two-word window belongs to the access when it lies in
   // [off, off + bytes).
   generate
      for (genvar i = 0; i < 2*LANES; i++) begin : g_lane
         assign span[i] = (i >= int'(off)) && (i < int'(off) + size_bytes(size));
      end
   endgenerate

   assign wkeep = XLEN'(({{XLEN{1'b0}}, 1'b1} << (8 * size_bytes(size))) - 1'b1);

   assign {wd_hi, wd_lo} = {{XLEN{1'b0}}, wdata & wkeep} << (8 * int'(off));

   assign be_lo = span[LANES-1:0];
   assign be_hi = span[2*LANES-1:LANES];
   assign split = |be_hi;

endmodule

// File: rtl/lsu_load_merge.sv
module lsu_load_merge
   import lsu_pkg::*;
#(
   parameter int XLEN = 64,
   localparam int LANES = XLEN / 8,
   localparam int OFF_W = $clog2(LANES)
) (
   input  logic [XLEN-1:0]  rd_lo,
   input  logic [XLEN-1:0]  rd_hi,
   input  logic [OFF_W-1:0] off,
   input  lsu_size_e        size,
   output logic [XLEN-1:0]  data
);
   logic [XLEN-1:0] keep;

   assign keep = XLEN'(({{XLEN{1'b0}}, 1'b1} << (8 * size_bytes(size))) - 1'b1);
   assign data = XLEN'({rd_hi, rd_lo} >> (8 * int'(off))) & keep;

endmodule

// File: rtl/sized_lsu.sv
module sized_lsu
   import lsu_pkg::*;
#(
   parameter int              XLEN        = 64,
   parameter int              AW          = 64,
   parameter int              OP_W        = 8,
   parameter int              OP_LOAD0    = 30,
   parameter int              OP_STORE0   = 34,
   parameter longint unsigned GUARD_BYTES = 4096,
   localparam int LANES = XLEN / 8,
   localparam int OFF_W = $clog2(LANES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [OP_W-1:0]  req_op,
   input  logic [AW-1:0]    req_base,
   input  logic [AW-1:0]    req_imm,
   input  logic [XLEN-1:0]  req_wdata,
   input  logic [AW-1:0]    win_lo,
   input  logic [AW-1:0]    win_hi,
   output logic             req_ready,
   output logic             mem_en,
   output logic             mem_we,
   output logic [AW-1:0]    mem_addr,
   output logic [LANES-1:0] mem_be,
   output logic [XLEN-1:0]  mem_wdata,
   input  logic [XLEN-1:0]  mem_rdata,
   output logic             resp_valid,
   output logic             resp_wb_en,
   output logic [XLEN-1:0]  resp_data,
   output logic             trap_valid,
   output logic             trap_store,
   output logic [AW-1:0]    trap_addr
);
   generate
      if (XLEN < 64 || (XLEN & (XLEN - 1)) != 0) begin : g_bad_xlen
         $error("sized_lsu: XLEN must be a power of two of at least 64");
      end
      if (AW <= OFF_W) begin : g_bad_aw
         $error("sized_lsu: AW too small for the word width");
      end
      if (GUARD_BYTES < 4096) begin : g_bad_guard
         $error("sized_lsu: the guard region must cover the first 4 KiB");
      end
      if (OP_STORE0 < OP_LOAD0 + 4 && OP_LOAD0 < OP_STORE0 + 4) begin : g_bad_ops
         $error("sized_lsu: load and store opcode ranges overlap");
      end
   endgenerate

   // ---------------- request decode ----------------
   logic       ld_op, st_op, acc_take;
   lsu_size_e  req_size;

   assign ld_op    = (int'(req_op) >= OP_LOAD0)  && (int'(req_op) < OP_LOAD0 + 4);
   assign st_op    = (int'(req_op) >= OP_STORE0) && (int'(req_op) < OP_STORE0 + 4);
   assign req_size = lsu_size_e'(2'(int'(req_op) - (st_op ? OP_STORE0 : OP_LOAD0)));

   lsu_state_e state;
   assign req_ready = (state == LS_IDLE);
   assign acc_take  = req_valid && req_ready && (ld_op || st_op);

   // ---------------- shared address check ----------------
   logic [AW-1:0] ea;
   logic          ea_bad;

   lsu_addr_check #(.AW(AW), .GUARD_BYTES(GUARD_BYTES)) u_check (
      .base   (req_base),
      .imm    (req_imm),
      .size   (req_size),
      .win_lo (win_lo),
      .win_hi (win_hi),
      .ea     (ea),
      .bad    (ea_bad)
   );

   // ---------------- held access ----------------
   logic [AW-1:0]   ea_q;
   lsu_size_e       size_q;
   logic            st_q;
   logic [XLEN-1:0] wdata_q;
   logic [XLEN-1:0] rd_lo_q;

   logic [LANES-1:0] be_lo, be_hi;
   logic             split;
   logic [XLEN-1:0]  wd_lo, wd_hi;

   lsu_lane_map #(.XLEN(XLEN)) u_lanes (
      .off   (ea_q[OFF_W-1:0]),
      .size  (size_q),
      .wdata (wdata_q),
      .be_lo (be_lo),
      .be_hi (be_hi),
      .split (split),
      .wd_lo (wd_lo),
      .wd_hi (wd_hi)
   );

   logic [XLEN-1:0] merged;

   lsu_load_merge #(.XLEN(XLEN)) u_merge (
      .rd_lo (split ? rd_lo_q : mem_rdata),
      .rd_hi (mem_rdata),
      .off   (ea_q[OFF_W-1:0]),
      .size  (size_q),
      .data  (merged)
   );

   // ---------------- memory port ----------------
   logic          hi_phase;
   logic [AW-1:0] word_addr;

   assign hi_phase  = (state == LS_HI);
   assign word_addr = {ea_q[AW-1:OFF_W], {OFF_W{1'b0}}};

   assign mem_en    = (state == LS_LO) || hi_phase;
   assign mem_we    = mem_en && st_q;
   assign mem_addr  = word_addr + (hi_phase ? AW'(LANES) : '0);
   assign mem_be    = !mem_en ? '0 : (hi_phase ? be_hi : be_lo);
   assign mem_wdata = hi_phase ? wd_hi : wd_lo;

   // ---------------- sequencing and response ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= LS_IDLE;
         ea_q       <= '0;
         size_q     <= LSZ_BYTE;
         st_q       <= 1'b0;
         wdata_q    <= '0;
         rd_lo_q    <= '0;
         resp_valid <= 1'b0;
         resp_wb_en <= 1'b0;
         resp_data  <= '0;
         trap_valid <= 1'b0;
         trap_store <= 1'b0;
         trap_addr  <= '0;
      end else begin
         resp_valid <= 1'b0;
         resp_wb_en <= 1'b0;
         trap_valid <= 1'b0;
         unique case (state)
            LS_IDLE: begin
               if (acc_take) begin
                  ea_q    <= ea;
                  size_q  <= req_size;
                  st_q    <= st_op;
                  wdata_q <= req_wdata;
                  if (ea_bad) begin
                     resp_valid <= 1'b1;
                     trap_valid <= 1'b1;
                     trap_store <= st_op;
                     trap_addr  <= ea;
                  end else begin
                     state <= LS_LO;
                  end
               end
            end
            LS_LO:   state <= split ? LS_HI : LS_DONE;
            LS_HI: begin
               rd_lo_q <= mem_rdata;
               state   <= LS_DONE;
            end
            LS_DONE: begin
               resp_valid <= 1'b1;
               resp_wb_en <= !st_q;
               resp_data  <= st_q ? '0 : merged;
               state      <= LS_IDLE;
            end
            default: state <= LS_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/lsu_checker.sv
module lsu_checker #(
   parameter int              XLEN        = 64,
   parameter int              AW          = 64,
   parameter int              OP_W        = 8,
   parameter int              OP_LOAD0    = 30,
   parameter int              OP_STORE0   = 34,
   parameter longint unsigned GUARD_BYTES = 4096,
   localparam int LANES = XLEN / 8,
   localparam int OFF_W = $clog2(LANES)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic [OP_W-1:0]  req_op,
   input logic [AW-1:0]    req_base,
   input logic [AW-1:0]    req_imm,
   input logic [AW-1:0]    win_lo,
   input logic [AW-1:0]    win_hi,
   input logic             req_ready,
   input logic             mem_en,
   input logic             mem_we,
   input logic [AW-1:0]    mem_addr,
   input logic [LANES-1:0] mem_be,
   input logic             resp_valid,
   input logic             resp_wb_en,
   input logic             trap_valid,
   input logic [AW-1:0]    trap_addr
);
   logic          c_ld, c_st, c_take;
   logic [AW-1:0] c_ea;
   logic [AW:0]   c_last;
   logic          c_bad;
   int            c_bytes;

   assign c_ld    = (int'(req_op) >= OP_LOAD0)  && (int'(req_op) < OP_LOAD0 + 4);
   assign c_st    = (int'(req_op) >= OP_STORE0) && (int'(req_op) < OP_STORE0 + 4);
   assign c_take  = req_valid && req_ready;
   assign c_bytes = 1 << ((int'(req_op) - (c_st ? OP_STORE0 : OP_LOAD0)) & 3);
   assign c_ea    = req_base + req_imm;
   assign c_last  = {1'b0, c_ea} + (AW+1)'(c_bytes - 1);
   assign c_bad   = (c_ea < AW'(GUARD_BYTES)) || (c_ea < win_lo) || c_last[AW]
                 || (c_last[AW-1:0] > win_hi);

   logic          ign_q, bad_q, ok_q;
   logic [AW-1:0] ea_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ign_q <= 1'b0;
         bad_q <= 1'b0;
         ok_q  <= 1'b0;
         ea_q  <= '0;
      end else begin
         ign_q <= c_take && !(c_ld || c_st);
         bad_q <= c_take && (c_ld || c_st) && c_bad;
         ok_q  <= c_take && (c_ld || c_st) && !c_bad;
         ea_q  <= c_ea;
      end
   end

   p_ignored_op_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ign_q |-> (!mem_en && !resp_valid));

   p_be_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_en |-> (mem_be != '0));

   p_we_with_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> mem_en);

   p_bad_traps_r6: assert property (@(posedge clk) disable iff (!rst_n)
      bad_q |-> (trap_valid && trap_addr == ea_q));

   p_trap_no_wb_r7: assert property (@(posedge clk) disable iff (!rst_n)
      trap_valid |-> (resp_valid && !resp_wb_en));

   p_trap_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      trap_valid |-> (!mem_en && !mem_we));

   p_ok_issues_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ok_q |-> (mem_en && !resp_valid && mem_addr[OFF_W-1:0] == '0));

   p_busy_not_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_en |-> !req_ready);

endmodule

bind sized_lsu lsu_checker #(
   .XLEN(XLEN), .AW(AW), .OP_W(OP_W), .OP_LOAD0(OP_LOAD0),
   .OP_STORE0(OP_STORE0), .GUARD_BYTES(GUARD_BYTES)
) u_lsu_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_op     (req_op),
   .req_base   (req_base),
   .req_imm    (req_imm),
   .win_lo     (win_lo),
   .win_hi     (win_hi),
   .req_ready  (req_ready),
   .mem_en     (mem_en),
   .mem_we     (mem_we),
   .mem_addr   (mem_addr),
   .mem_be     (mem_be),
   .resp_valid (resp_valid),
   .resp_wb_en (resp_wb_en),
   .trap_valid (trap_valid),
   .trap_addr  (trap_addr)
);

// File: tb/test_sized_lsu.sv
module test_sized_lsu;
   localparam int          CLK_PERIOD = 10;
   localparam logic [63:0] WIN_BASE   = 64'h1000;
   localparam logic [63:0] WIN_TOP    = 64'h11FF;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid;
   logic [7:0]  req_op;
   logic [63:0] req_base, req_imm, req_wdata, win_lo, win_hi;
   logic        req_ready, mem_en, mem_we;
   logic [63:0] mem_addr;
   logic [7:0]  mem_be;
   logic [63:0] mem_wdata;
   logic [63:0] mem_rdata;
   logic        resp_valid, resp_wb_en, trap_valid, trap_store;
   logic [63:0] resp_data, trap_addr;

   always #(CLK_PERIOD/2) clk = ~clk;

   sized_lsu i_sized_lsu (.*);

   int nchk = 0;
   int nerr = 0;

   // Byte-wide memory behind the port, and the bench's own expectation.
   logic [7:0] mem_b  [512];
   logic [7:0] shadow [512];
   int         mem_cycles;

   function automatic int bidx(logic [63:0] a);
      return int'(9'(a - WIN_BASE));
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 512; i++) mem_b[i] <= 8'(i * 7 + 3);
         mem_cycles <= 0;
         mem_rdata  <= '0;
      end else if (mem_en) begin
         for (int i = 0; i < 8; i++) begin
            if (mem_we && mem_be[i]) mem_b[bidx(mem_addr + 64'(i))] <= mem_wdata[8*i +: 8];
            mem_rdata[8*i +: 8] <= mem_b[bidx(mem_addr + 64'(i))];
         end
         mem_cycles <= mem_cycles + 1;
      end
   end

   task automatic report();
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual=running expected=finished");
      report();
   end

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic mem_match(input string tag);
      int bad = 0;
      for (int i = 0; i < 512; i++) if (mem_b[i] !== shadow[i]) bad++;
      chk(tag, 64'(bad), 64'd0);
   endtask

   int          r_k, r_mcyc;
   logic        r_rv, r_trap, r_store, r_wb;
   logic [63:0] r_addr, r_data;

   task automatic run(input logic [7:0] op, input logic [63:0] base, input logic [63:0] imm,
                      input logic [63:0] wd);
      int m0;
      @(negedge clk);
      req_valid = 1'b1; req_op = op; req_base = base; req_imm = imm; req_wdata = wd;
      m0 = mem_cycles;
      @(negedge clk);
      req_valid = 1'b0;
      r_k = 0;
      while (!resp_valid && r_k < 8) begin
         @(negedge clk);
         r_k++;
      end
      r_rv = resp_valid; r_trap = trap_valid; r_store = trap_store; r_wb = resp_wb_en;
      r_addr = trap_addr; r_data = resp_data; r_mcyc = mem_cycles - m0;
   endtask

   function automatic bit crosses(logic [63:0] ea, int n);
      return (int'(ea[2:0]) + n) > 8;
   endfunction

   task automatic do_store(input int sz, input logic [63:0] base, input logic [63:0] imm,
                           input logic [63:0] wd, input string tag);
      logic [63:0] ea = base + imm;
      int          n  = 1 << sz;
      bit          sp = crosses(ea, n);
      for (int b = 0; b < n; b++) shadow[bidx(ea + 64'(b))] = wd[8*b +: 8];
      run(8'(34 + sz), base, imm, wd);
      chk({tag, " R1 store response"}, {61'd0, r_rv, r_trap, r_wb}, 64'b100);
      chk({tag, " R9 latency"}, 64'(r_k), sp ? 64'd3 : 64'd2);
      chk({tag, " R5 memory cycles"}, 64'(r_mcyc), sp ? 64'd2 : 64'd1);
      mem_match({tag, " R3 memory bytes"});
   endtask

   task automatic do_load(input int sz, input logic [63:0] base, input logic [63:0] imm,
                          input string tag);
      logic [63:0] ea  = base + imm;
      int          n   = 1 << sz;
      bit          sp  = crosses(ea, n);
      logic [63:0] exp = '0;
      for (int b = 0; b < n; b++) exp[8*b +: 8] = shadow[bidx(ea + 64'(b))];
      run(8'(30 + sz), base, imm, 64'hA5A5_5A5A_DEAD_BEEF);
      chk({tag, " R1 load response"}, {61'd0, r_rv, r_trap, r_wb}, 64'b101);
      chk({tag, " R4 R10 load data"}, r_data, exp);
      chk({tag, " R9 latency"}, 64'(r_k), sp ? 64'd3 : 64'd2);
      chk({tag, " R5 memory cycles"}, 64'(r_mcyc), sp ? 64'd2 : 64'd1);
   endtask

   task automatic do_trap(input logic [7:0] op, input logic [63:0] base, input logic [63:0] imm,
                          input string tag);
      run(op, base, imm, 64'h0123_4567_89AB_CDEF);
      chk({tag, " R6 R7 trap response"}, {61'd0, r_rv, r_trap, r_wb}, 64'b110);
      chk({tag, " R7 trap kind"}, {63'd0, r_store}, {63'd0, op >= 8'd34});
      chk({tag, " R7 trap address"}, r_addr, base + imm);
      chk({tag, " R7 trap timing"}, 64'(r_k), 64'd0);
      chk({tag, " R8 no memory cycle"}, 64'(r_mcyc), 64'd0);
      mem_match({tag, " R8 memory untouched"});
   endtask

   task automatic t_reset();
      chk("R11 ready after reset", {63'd0, req_ready}, 64'd1);
      chk("R11 no memory cycle in reset", {63'd0, mem_en}, 64'd0);
      chk("R11 no response in reset", {62'd0, resp_valid, trap_valid}, 64'd0);
   endtask

   task automatic t_aligned();
      do_store(3, 64'h1000, 64'h8, 64'h8877_6655_4433_2211, "aligned dword");
      do_load (3, 64'h1000, 64'h8, "aligned dword");
      do_load (2, 64'h1010, 64'h0, "aligned word untouched");
   endtask

   task automatic t_sizes();
      do_store(3, 64'h1020, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, "fill ones");
      do_store(0, 64'h1021, 64'h0, 64'h1234_5678_9ABC_DE5A, "byte lane 1");
      do_store(1, 64'h1020, 64'h4, 64'h0000_0000_0000_BEEF, "half lane 4");
      do_load (0, 64'h1021, 64'h0, "byte zero-extend");
      do_load (1, 64'h1024, 64'h0, "half zero-extend");
      do_load (2, 64'h1020, 64'h0, "word mixed lanes");
      do_load (0, 64'h1027, 64'h0, "byte 0xFF zero-extend");
      do_load (3, 64'h1020, 64'h0, "dword after narrow stores");
   endtask

   task automatic t_cross();
      do_store(2, 64'h1036, 64'h0, 64'hCAFE_F00D_1357_9BDF, "word crossing");
      do_store(1, 64'h103F, 64'h0, 64'h0000_0000_0000_A1B2, "half crossing");
      do_store(3, 64'h1045, 64'h0, 64'h0F1E_2D3C_4B5A_6978, "dword crossing");
      do_load (3, 64'h1033, 64'h0, "dword crossing");
      do_load (2, 64'h1036, 64'h0, "word crossing");
      do_load (1, 64'h103F, 64'h0, "half crossing");
      do_load (3, 64'h1045, 64'h0, "dword crossing back");
   endtask

   task automatic t_ea_wrap();
      do_store(3, 64'hFFFF_FFFF_FFFF_F000, 64'h2040, 64'h1122_3344_5566_7788, "R2 wrapped sum");
      do_load (3, 64'h1040, 64'h0, "R2 wrapped sum readback");
   endtask

   task automatic t_traps();
      do_trap(8'd32, 64'h11FE, 64'h0, "load past top");
      do_trap(8'd34, 64'h1000, 64'hFFFF_FFFF_FFFF_FFFF, "store below window");
      do_trap(8'd37, 64'h11F9, 64'h0, "dword store past top");
      do_load(0, 64'h11FF, 64'h0, "R6 last byte at top");
      do_load(3, 64'h11F8, 64'h0, "R6 dword ending at top");
      win_lo = 64'h0;
      do_trap(8'd30, 64'h0, 64'h0, "null address");
      do_trap(8'd35, 64'hFFF, 64'h0, "guard page store");
      do_trap(8'd31, 64'h0F00, 64'h0FF, "guard page load");
      do_load(0, 64'h1000, 64'h0, "R6 first byte past guard");
      win_hi = 64'hFFFF_FFFF_FFFF_FFFF;
      do_trap(8'd33, 64'hFFFF_FFFF_FFFF_FFFC, 64'h0, "tail wraps top");
      do_load(0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, "R6 top byte valid");
      win_lo = WIN_BASE;
      win_hi = WIN_TOP;
   endtask

   task automatic t_ignored(input logic [7:0] op);
      int m0;
      bit seen = 1'b0;
      @(negedge clk);
      req_valid = 1'b1; req_op = op; req_base = 64'h1000; req_imm = 64'h0;
      req_wdata = 64'hFFFF_FFFF_FFFF_FFFF;
      m0 = mem_cycles;
      @(negedge clk);
      req_valid = 1'b0;
      for (int c = 0; c < 4; c++) begin
         if (resp_valid || mem_en || !req_ready) seen = 1'b1;
         @(negedge clk);
      end
      chk($sformatf("R1 opcode %0d ignored", op), {63'd0, seen}, 64'd0);
      chk($sformatf("R1 opcode %0d no memory cycle", op), 64'(mem_cycles - m0), 64'd0);
      mem_match($sformatf("R1 opcode %0d memory untouched", op));
   endtask

   initial begin
      for (int i = 0; i < 512; i++) shadow[i] = 8'(i * 7 + 3);
      rst_n = 1'b0; req_valid = 1'b0; req_op = '0;
      req_base = '0; req_imm = '0; req_wdata = '0;
      win_lo = WIN_BASE; win_hi = WIN_TOP;
      repeat (4) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_aligned();
      t_sizes();
      t_cross();
      t_ea_wrap();
      t_traps();
      t_ignored(8'd29);
      t_ignored(8'd38);
      t_ignored(8'd0);
      do_load(3, 64'h1020, 64'h0, "final readback");
      report();
   end

endmodule